// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Engine

This block copies a region of memory to another region, one byte per trigger pulse, by borrowing a shared byte-wide bus from the CPU. A single trigger, normally from a periodic timer, raises a request on both channels in the same cycle. Channel 0 always wins the bus first. It reads one byte from its source pointer and writes the byte into a fixed one-byte scratch location. Once it has handed the bus back, channel 1 reads the scratch byte and writes it to its destination pointer. The copy is therefore staged through the scratch byte. The CPU may take the bus back between the two channel transfers.

Each channel has a source pointer, a destination pointer, a transfer counter and increment enables. Software loads them through a small configuration write port. The reset defaults already describe a 128-byte copy. Channel 0 reads from 0xF8000 upward into scratch 0x00800. Channel 1 reads from scratch 0x00800 and writes to 0x00400 upward. When a channel's counter reaches zero, the channel turns itself off and pulses its done bit.

One sequencer state machine owns the bus, and it has five states:
- IDLE: waits for a pending request, then latches the winning channel and moves to REQ.
- REQ: holds `bus_req` high. It stays in REQ until `bus_gnt` is sampled high, then moves to READ.
- READ: drives the source address with `mem_rd` high for one cycle, captures `mem_rdata`, then moves to WRITE.
- WRITE: drives the destination address with `mem_wr` high and the captured byte on `mem_wdata` for one cycle. It signals transfer completion to the channel, then moves to RELEASE.
- RELEASE: holds `bus_req` low for one cycle, then returns to IDLE.

Top module: `dma2_cyclesteal`

## Requirements
- R1: After reset, `bus_req`, `mem_rd`, `mem_wr` and both `done` bits are low. No bus cycle occurs until a trigger arrives.
- R2: One cycle of `trig` raises a pending request on both channels together. Each enabled channel then performs exactly one transfer.
- R3: When both channels are pending, the channel 0 transfer (read source, write scratch) happens entirely before the channel 1 transfer (read scratch, write destination).
- R4: `bus_req` is high only from REQ through WRITE. `mem_rd` rises only in the cycle after `bus_gnt` was sampled high. If the grant is late, the sequencer waits in REQ for as long as it takes.
- R5: A transfer is one `mem_rd` cycle at the source address, then, in the next cycle, one `mem_wr` cycle at the destination address. During the write cycle `mem_wdata` carries the byte read. `mem_rd` and `mem_wr` are never high together.
- R6: After every write cycle, `bus_req` is low for at least one cycle before the next read, so the CPU can take the bus between the two channel transfers.
- R7: With increment enabled, a channel's source or destination pointer advances by one after each transfer; otherwise it stays fixed. The defaults are as follows. Channel 0 has source 0xF8000 incrementing and destination 0x00800 fixed. Channel 1 has source 0x00800 fixed and destination 0x00400 incrementing. Both counts are 128.
- R8: The counter drops by one per completed transfer. The transfer that takes it to zero clears the channel's enable. That channel's `done` bit is then high for exactly one cycle, and later triggers cause no bus activity on that channel.
- R9: A trigger that arrives while a channel's request is still pending merges into that request, so two back-to-back trigger cycles give only one transfer per channel.
- R10: A configuration write (`cfg_we` high for one cycle) updates one register of channel `cfg_ch`, chosen by `cfg_sel`:
  - 0: source pointer.
  - 1: destination pointer.
  - 2: count, taken from the low bits of `cfg_wdata`.
  - 3: control, where bit 0 is enable, bit 1 is source increment and bit 2 is destination increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Transfer trigger pulse, arms both channels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel selected for the configuration write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 20 | Configuration write data |
| bus_req | output | 1 | Bus request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| mem_addr | output | 20 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data from memory |
| mem_wdata | output | 8 | Write data to memory |
| done | output | 2 | Per-channel one-cycle terminal-count pulse |

## Verification
Two events can land in the same cycle:
- A trigger and an already-pending request on the same channel. The bench provokes this by holding `trig` high for two cycles. The scoreboard, fed with a single set of four bus operations, then flags any surplus read or write as unexpected.
- The completion of channel 0 and the still-pending request of channel 1. Here the release gap between the two transfers is judged by a monitor that requires `bus_req` to be seen low after every write and before the next read. A delayed grant is added to show that no read starts before the grant.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_REQ     = 3'd1,
        S_READ    = 3'd2,
        S_WRITE   = 3'd3,
        S_RELEASE = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        CFG_SRC  = 2'd0,
        CFG_DST  = 2'd1,
        CFG_CNT  = 2'd2,
        CFG_CTRL = 2'd3
    } cfg_sel_t;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SINC_BIT = 1;
    localparam int CTRL_DINC_BIT = 2;

endpackage

// File: rtl/dma2_channel.sv
module dma2_channel
    import dma2_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter int                CNT_W    = 8,
    parameter logic [ADDR_W-1:0] SRC_RST  = '0,
    parameter logic [ADDR_W-1:0] DST_RST  = '0,
    parameter logic [CNT_W-1:0]  CNT_RST  = '0,
    parameter bit                SINC_RST = 1'b0,
    parameter bit                DINC_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              xfer_done,
    output logic              pend,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic              done
);

    logic [ADDR_W-1:0] src_q, src_n;
    logic [ADDR_W-1:0] dst_q, dst_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              en_q, en_n;
    logic              sinc_q, sinc_n;
    logic              dinc_q, dinc_n;
    logic              pend_q, pend_n;
    logic              done_q, done_n;
    logic              last_xfer;

    assign last_xfer = xfer_done && (cnt_q == CNT_W'(1));

    always_comb begin
        src_n  = src_q;
        dst_n  = dst_q;
        cnt_n  = cnt_q;
        en_n   = en_q;
        sinc_n = sinc_q;
        dinc_n = dinc_q;
        if (xfer_done) begin
            if (sinc_q) src_n = src_q + ADDR_W'(1);
            if (dinc_q) dst_n = dst_q + ADDR_W'(1);
            cnt_n = cnt_q - CNT_W'(1);
        end
        if (last_xfer) en_n = 1'b0;
        if (cfg_we) begin
            unique case (cfg_sel_t'(cfg_sel))
                CFG_SRC:  src_n = cfg_wdata;
                CFG_DST:  dst_n = cfg_wdata;
                CFG_CNT:  cnt_n = cfg_wdata[CNT_W-1:0];
                CFG_CTRL: begin
                    en_n   = cfg_wdata[CTRL_EN_BIT];
                    sinc_n = cfg_wdata[CTRL_SINC_BIT];
                    dinc_n = cfg_wdata[CTRL_DINC_BIT];
                end
                default: ;
            endcase
        end
        pend_n = en_n && (cnt_n != '0) && (trig || (pend_q && !xfer_done));
        done_n = last_xfer;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= SRC_RST;
            dst_q  <= DST_RST;
            cnt_q  <= CNT_RST;
            en_q   <= 1'b1;
            sinc_q <= SINC_RST;
            dinc_q <= DINC_RST;
            pend_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            src_q  <= src_n;
            dst_q  <= dst_n;
            cnt_q  <= cnt_n;
            en_q   <= en_n;
            sinc_q <= sinc_n;
            dinc_q <= dinc_n;
            pend_q <= pend_n;
            done_q <= done_n;
        end
    end

    assign pend = pend_q;
    assign src  = src_q;
    assign dst  = dst_q;
    assign done = done_q;

    assert_off_not_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pend_q);

    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_done_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !$past(cfg_we)) |-> !en_q);

endmodule

// File: rtl/dma2_prio.sv
module dma2_prio #(
    parameter int NCH   = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req,
    output logic             valid,
    output logic [SEL_W-1:0] sel
);

    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) sel = SEL_W'(i);
        end
    end

    assign valid = |req;

    assert_low_index_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> (valid && sel == '0));

    assert_winner_requests_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[sel]);

endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int NCH    = 2,
    parameter int SEL_W  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         win_valid,
    input  logic [SEL_W-1:0]             win_sel,
    input  logic [NCH-1:0][ADDR_W-1:0]   src_all,
    input  logic [NCH-1:0][ADDR_W-1:0]   dst_all,
    input  logic                         bus_gnt,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         bus_req,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic                         mem_rd,
    output logic                         mem_wr,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic [NCH-1:0]               xfer_done
);

    seq_state_t        state_q, state_n;
    logic [SEL_W-1:0]  cur_q;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:    if (win_valid) state_n = S_REQ;
            S_REQ:     if (bus_gnt)   state_n = S_READ;
            S_READ:    state_n = S_WRITE;
            S_WRITE:   state_n = S_RELEASE;
            S_RELEASE: state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == S_IDLE && win_valid) cur_q <= win_sel;
            if (state_q == S_READ) hold_q <= mem_rdata;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        xfer_done = '0;
        unique case (state_q)
            S_IDLE: ;
            S_REQ:  bus_req = 1'b1;
            S_READ: begin
                bus_req  = 1'b1;
                mem_rd   = 1'b1;
                mem_addr = src_all[cur_q];
            end
            S_WRITE: begin
                bus_req   = 1'b1;
                mem_wr    = 1'b1;
                mem_addr  = dst_all[cur_q];
                mem_wdata = hold_q;
                xfer_done[cur_q] = 1'b1;
            end
            S_RELEASE: ;
            default: ;
        endcase
    end

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_read_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> $past(bus_gnt));

    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    assert_release_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr) |-> !bus_req);

    assert_read_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && mem_wr));

endmodule

// File: rtl/dma2_cyclesteal.sv
module dma2_cyclesteal
    import dma2_pkg::*;
#(
    parameter int               ADDR_W    = 20,
    parameter int               DATA_W    = 8,
    parameter int               XFERS     = 128,
    parameter logic [ADDR_W-1:0] SRC_BASE = 20'hF8000,
    parameter logic [ADDR_W-1:0] DST_BASE = 20'h00400,
    parameter logic [ADDR_W-1:0] SCRATCH  = 20'h00800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              cfg_we,
    input  logic              cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [1:0]        done
);

    localparam int NCH   = 2;
    localparam int SEL_W = 1;
    localparam int CNT_W = $clog2(XFERS + 1);

    logic [NCH-1:0]             pend;
    logic [NCH-1:0]             xfer_done;
    logic [NCH-1:0][ADDR_W-1:0] src_w;
    logic [NCH-1:0][ADDR_W-1:0] dst_w;
    logic                       win_valid;
    logic [SEL_W-1:0]           win_sel;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam bit IS_FIRST = (g == 0);
        dma2_channel #(
            .ADDR_W   (ADDR_W),
            .CNT_W    (CNT_W),
            .SRC_RST  (IS_FIRST ? SRC_BASE : SCRATCH),
            .DST_RST  (IS_FIRST ? SCRATCH : DST_BASE),
            .CNT_RST  (CNT_W'(XFERS)),
            .SINC_RST (IS_FIRST),
            .DINC_RST (!IS_FIRST)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig      (trig),
            .cfg_we    (cfg_we && (cfg_ch == SEL_W'(g))),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .xfer_done (xfer_done[g]),
            .pend      (pend[g]),
            .src       (src_w[g]),
            .dst       (dst_w[g]),
            .done      (done[g])
        );
    end

    dma2_prio #(
        .NCH   (NCH),
        .SEL_W (SEL_W)
    ) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pend),
        .valid (win_valid),
        .sel   (win_sel)
    );

    dma2_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NCH    (NCH),
        .SEL_W  (SEL_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_sel   (win_sel),
        .src_all   (src_w),
        .dst_all   (dst_w),
        .bus_gnt   (bus_gnt),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .xfer_done (xfer_done)
    );

    assert_no_stray_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(|pend));

endmodule

// File: tb/dma2_cyclesteal_tb.sv
module dma2_cyclesteal_tb;

    localparam logic [19:0] SCR = 20'h00800;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trig;
    logic        cfg_we;
    logic        cfg_ch;
    logic [1:0]  cfg_sel;
    logic [19:0] cfg_wdata;
    logic        bus_req;
    logic        bus_gnt;
    logic [19:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic [1:0]  done;

    always #2 clk = ~clk;

    dma2_cyclesteal u_dut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .done(done)
    );

    typedef struct packed {
        logic        wr;
        logic [19:0] a;
        logic [7:0]  d;
    } op_t;

    op_t  expq[$];
    int   checks = 0;
    int   errors = 0;
    int   ops_seen = 0;
    int   req_cycles = 0;
    int   done_hi0 = 0;
    int   done_hi1 = 0;
    int   stall_left = 0;
    logic [7:0]  scratch = 8'h00;
    logic [19:0] s_ptr = 20'hF8000;
    logic [19:0] d_ptr = 20'h00400;
    bit   after_wr = 1'b0;
    bit   saw_low = 1'b0;

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: scratch byte is real storage, everything else a pattern
    always_comb mem_rdata = (mem_addr == SCR) ? scratch : pat(mem_addr);

    // CPU grant model, updated away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0;
        end else begin
            if (bus_req && stall_left > 0) stall_left <= stall_left - 1;
            bus_gnt <= bus_req && (stall_left == 0);
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) req_cycles++;
            else saw_low = 1'b1;
            if (done[0]) done_hi0++;
            if (done[1]) done_hi1++;
            if (mem_rd || mem_wr) begin
                ops_seen++;
                if (mem_rd) begin
                    chk(bus_gnt, "R4", "read without prior grant", 32'(bus_gnt), 32'd1);
                    if (after_wr)
                        chk(saw_low, "R6", "no bus release before read", 32'(saw_low), 32'd1);
                end
                if (expq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected bus op addr", 32'(mem_addr), 32'h0);
                end else begin
                    op_t e;
                    e = expq.pop_front();
                    chk(mem_wr == e.wr, "R3 R5", "op kind", 32'(mem_wr), 32'(e.wr));
                    chk(mem_addr == e.a, "R7", "address", 32'(mem_addr), 32'(e.a));
                    if (mem_wr)
                        chk(mem_wdata == e.d, "R5", "write data", 32'(mem_wdata), 32'(e.d));
                end
                if (mem_wr) begin
                    if (mem_addr == SCR) scratch = mem_wdata;
                    after_wr = 1'b1;
                    saw_low  = 1'b0;
                end
            end
        end
    end

    task automatic push_pair();
        logic [7:0] b;
        b = pat(s_ptr);
        expq.push_back('{wr: 1'b0, a: s_ptr, d: 8'h00});
        expq.push_back('{wr: 1'b1, a: SCR,   d: b});
        expq.push_back('{wr: 1'b0, a: SCR,   d: 8'h00});
        expq.push_back('{wr: 1'b1, a: d_ptr, d: b});
        s_ptr = s_ptr + 20'd1;
        d_ptr = d_ptr + 20'd1;
    endtask

    task automatic pulse(input int len);
        trig = 1'b1;
        repeat (len) @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic settle(input int extra);
        while (expq.size() != 0) @(negedge clk);
        repeat (extra) @(negedge clk);
    endtask

    task automatic cfg(input bit ch, input logic [1:0] sel, input logic [19:0] v);
        cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ops0;
        int req0;
        rst_n = 1'b0; trig = 1'b0; cfg_we = 1'b0; cfg_ch = 1'b0;
        cfg_sel = 2'd0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!bus_req, "R1", "bus_req at reset", 32'(bus_req), 32'd0);
        chk(!mem_rd && !mem_wr, "R1", "strobes at reset", {30'd0, mem_rd, mem_wr}, 32'd0);
        chk(done == 2'b00, "R1", "done at reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(ops_seen == 0 && req_cycles == 0, "R1", "activity without trigger",
            32'(ops_seen + req_cycles), 32'd0);

        // R2 R3 R7 one trigger, default programming
        push_pair();
        pulse(1);
        settle(10);
        chk(ops_seen == 4, "R2", "ops per trigger", 32'(ops_seen), 32'd4);

        // R9 back-to-back trigger merges into pending request
        ops0 = ops_seen;
        push_pair();
        pulse(2);
        settle(20);
        chk(ops_seen - ops0 == 4, "R9", "ops after merged trigger", 32'(ops_seen - ops0), 32'd4);

        // R4 late grant: sequencer must wait
        ops0 = ops_seen;
        stall_left = 7;
        push_pair();
        pulse(1);
        settle(10);
        chk(ops_seen - ops0 == 4, "R4", "ops with delayed grant", 32'(ops_seen - ops0), 32'd4);

        // remaining transfers up to the count of 128
        for (int j = 3; j < 128; j++) begin
            if (j == 127)
                chk(done_hi0 == 0 && done_hi1 == 0, "R8", "early done",
                    32'(done_hi0 + done_hi1), 32'd0);
            push_pair();
            pulse(1);
            settle(3);
        end
        repeat (5) @(negedge clk);
        chk(done_hi0 == 1, "R8", "done[0] cycles", 32'(done_hi0), 32'd1);
        chk(done_hi1 == 1, "R8", "done[1] cycles", 32'(done_hi1), 32'd1);

        // R8 triggers ignored after terminal count
        ops0 = ops_seen;
        req0 = req_cycles;
        pulse(1);
        repeat (30) @(negedge clk);
        chk(req_cycles == req0, "R8", "bus_req after terminal count", 32'(req_cycles - req0), 32'd0);
        chk(ops_seen == ops0, "R8", "ops after terminal count", 32'(ops_seen - ops0), 32'd0);

        // R10 reprogram both channels through the configuration port
        cfg(1'b0, 2'd0, 20'h12340);
        cfg(1'b1, 2'd1, 20'h00A00);
        cfg(1'b0, 2'd2, 20'd2);
        cfg(1'b1, 2'd2, 20'd2);
        cfg(1'b0, 2'd3, 20'h3);
        cfg(1'b1, 2'd3, 20'h5);
        s_ptr = 20'h12340;
        d_ptr = 20'h00A00;
        for (int j = 0; j < 2; j++) begin
            push_pair();
            pulse(1);
            settle(8);
        end
        chk(done_hi0 == 2 && done_hi1 == 2, "R10", "done after reprogrammed count",
            32'(done_hi0 + done_hi1), 32'd4);
        ops0 = ops_seen;
        pulse(1);
        repeat (30) @(negedge clk);
        chk(ops_seen == ops0, "R10", "ops after reprogrammed count", 32'(ops_seen - ops0), 32'd0);
        chk(expq.size() == 0, "R2", "scoreboard drained", 32'(expq.size()), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule